// File: doc/BRIEF.md
# Serial Identifier CRC-8 Checker

This block accepts a 64-bit device identifier one bit per strobe, least significant bit first, and keeps a running 8-bit CRC over the bits it has taken. The identifier has three parts. The low byte is a family code, the next 48 bits are a serial number, and the top byte is a CRC over the first 56 bits. The running CRC starts from zero. It uses the generator x^8 + x^5 + x^4 + 1 in bit-reflected form.

The block has two uses. When a new identifier is being generated, the caller shifts in the family code and the serial number. After the 56th bit the register holds the byte to store as the top byte, and a flag marks that point. When an identifier is being checked, the caller shifts in all 64 bits. A correct identifier leaves the register at zero, and a "good" flag is raised. Bits offered after the 64th are ignored until a synchronous clear starts a new identifier.

Top module: `serial_id_crc8`

## Requirements
- R1: Each accepted bit forms the feedback f = bit XOR crc[0]. The register then shifts right by one with a zero entering bit 7. When f is 1 the result is XORed with 8'h8C, which sets bit 7 and toggles bits 3 and 2.
- R2: The bit count rises by exactly one for each accepted bit and never exceeds 64.
- R3: While the asynchronous active-low reset is asserted, the CRC is zero, the count is zero and both flags are low.
- R4: A synchronous clear sets the CRC and the count to zero on the next edge. It takes priority over a bit strobe in the same cycle, and that bit is not taken.
- R5: Once 56 bits have been taken, the CRC output equals the CRC of the family code and serial number, and `gen_done_o` is high exactly while the count is 56.
- R6: `crc_good_o` is high exactly when the count is 64 and the CRC is zero. A correct identifier raises it, and an identifier with any single bit flipped leaves it low.
- R7: While the count is 64, bit strobes change neither the CRC nor the count.
- R8: In a cycle with no strobe and no clear, the CRC and the count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of CRC and count |
| bit_vld_i | input | 1 | Strobe: `bit_i` carries a bit this cycle |
| bit_i | input | 1 | Serial identifier bit, LSB first |
| crc_o | output | 8 | Running CRC register |
| bit_cnt_o | output | 7 | Number of bits taken since clear |
| gen_done_o | output | 1 | High while the count is 56 (CRC byte ready) |
| crc_good_o | output | 1 | High when 64 bits are taken and the residue is zero |

## Verification
The hardest state to reach from the ports is a full count with a zero residue. It needs a whole identifier whose top byte is consistent with the other 56 bits, and random bits almost never produce one. The stimulus builds each random identifier with a bench-side CRC function and appends the result as the top byte. It then flips single bits in copies of those identifiers to produce near-miss failures. Random idle gaps inside the stream, extra strobes after the 64th bit, and a clear that coincides with a strobe cover the hold, ignore and priority paths.

// File: rtl/sid_pkg.sv
package sid_pkg;

  localparam int CRC_W = 8;

  typedef logic [CRC_W-1:0] crc_t;

  // One step of a right-shifting (reflected) CRC: feedback from bit 0.
  function automatic crc_t crc_step(input crc_t cur, input logic din, input crc_t poly);
    logic fb;
    crc_t nxt;
    fb  = din ^ cur[0];
    nxt = cur >> 1;
    if (fb) nxt = nxt ^ poly;
    return nxt;
  endfunction

endpackage

// File: rtl/sid_bit_counter.sv
module sid_bit_counter #(
  parameter int LIMIT = 64,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          full
);

  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (adv && cnt != LIM_V) cnt <= cnt + CW'(1);
  end

  assign full = (cnt == LIM_V);

endmodule

// File: rtl/sid_crc_shift.sv
module sid_crc_shift
  import sid_pkg::*;
#(
  parameter crc_t POLY = 8'h8C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift,
  input  logic din,
  output crc_t crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clr)   crc <= '0;
    else if (shift) crc <= crc_step(crc, din, POLY);
  end

endmodule

// File: rtl/serial_id_crc8.sv
module serial_id_crc8
  import sid_pkg::*;
#(
  parameter int   ID_BITS = 64,
  parameter crc_t POLY    = 8'h8C,
  parameter int   CNT_W   = $clog2(ID_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic [7:0]       crc_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             gen_done_o,
  output logic             crc_good_o
);

  localparam int DATA_BITS = ID_BITS - CRC_W;
  localparam logic [CNT_W-1:0] DATA_V = CNT_W'(DATA_BITS);

  // Named internal events, visible to the bound checker.
  logic full_w;
  logic take_bit;
  crc_t crc_q;

  assign take_bit = bit_vld_i & ~clr_i & ~full_w;

  sid_bit_counter #(
    .LIMIT (ID_BITS),
    .CW    (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_i),
    .adv   (take_bit),
    .cnt   (bit_cnt_o),
    .full  (full_w)
  );

  sid_crc_shift #(
    .POLY  (POLY)
  ) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_i),
    .shift (take_bit),
    .din   (bit_i),
    .crc   (crc_q)
  );

  assign crc_o      = crc_q;
  assign gen_done_o = (bit_cnt_o == DATA_V);
  assign crc_good_o = full_w & (crc_q == '0);

endmodule

// File: rtl/sid_crc_checker.sv
module sid_crc_checker
  import sid_pkg::*;
#(
  parameter int   ID_BITS = 64,
  parameter crc_t POLY    = 8'h8C,
  parameter int   CNT_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             bit_vld_i,
  input logic             bit_i,
  input logic             take_bit,
  input logic [7:0]       crc_o,
  input logic [CNT_W-1:0] bit_cnt_o,
  input logic             crc_good_o
);

  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(ID_BITS);

  p_crc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_bit |=> crc_o == crc_step($past(crc_o), $past(bit_i), POLY));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_bit |=> bit_cnt_o == $past(bit_cnt_o) + CNT_W'(1));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_o <= LIM_V);

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_o == '0) && (bit_cnt_o == '0));

  p_good_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_good_o) |-> $past(take_bit));

  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt_o == LIM_V && bit_vld_i && !clr_i) |=> $stable(crc_o) && $stable(bit_cnt_o));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld_i && !clr_i) |=> $stable(crc_o) && $stable(bit_cnt_o));

endmodule

bind serial_id_crc8 sid_crc_checker #(
  .ID_BITS (ID_BITS),
  .POLY    (POLY),
  .CNT_W   (CNT_W)
) u_sid_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .bit_vld_i  (bit_vld_i),
  .bit_i      (bit_i),
  .take_bit   (take_bit),
  .crc_o      (crc_o),
  .bit_cnt_o  (bit_cnt_o),
  .crc_good_o (crc_good_o)
);

// File: tb/test_serial_id_crc8.sv
module test_serial_id_crc8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clr_i;
  logic       bit_vld_i;
  logic       bit_i;
  logic [7:0] crc_o;
  logic [6:0] bit_cnt_o;
  logic       gen_done_o;
  logic       crc_good_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  serial_id_crc8 i_serial_id_crc8 (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .crc_o      (crc_o),
    .bit_cnt_o  (bit_cnt_o),
    .gen_done_o (gen_done_o),
    .crc_good_o (crc_good_o)
  );

  // Bench model of the generator: rotate-in form, taps at x^4/x^5 positions.
  function automatic logic [7:0] ref_step(input logic [7:0] c, input logic b);
    logic f;
    f = c[0] ^ b;
    return {f, c[7:1]} ^ {4'b0000, f, f, 2'b00};
  endfunction

  function automatic logic [7:0] ref_crc56(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < 56; k++) c = ref_step(c, d[k]);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive right after a falling edge, then wait for the next falling edge.
  task automatic put(input logic b, input logic v, input logic c);
    bit_i = b; bit_vld_i = v; clr_i = c;
    @(negedge clk);
  endtask

  task automatic do_clear();
    put(1'b0, 1'b0, 1'b1);
    bit_vld_i = 1'b0; clr_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] id;
    logic [7:0]  rc;
    rst_n = 1'b0; clr_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0;
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3 crc", crc_o, 0);
    check("R3 cnt", bit_cnt_o, 0);
    check("R3 good", crc_good_o, 0);
    check("R3 gen", gen_done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: all-zero identifier is valid (R6)
    for (int i = 0; i < 64; i++) put(1'b0, 1'b1, 1'b0);
    check("R6 zero id good", crc_good_o, 1);
    check("R2 zero id cnt", bit_cnt_o, 64);

    // Directed: clear coinciding with a strobe (R4)
    do_clear();
    put(1'b1, 1'b1, 1'b0);
    put(1'b1, 1'b1, 1'b0);
    check("R4 pre-clear cnt", bit_cnt_o, 2);
    put(1'b1, 1'b1, 1'b1);
    check("R4 clear cnt", bit_cnt_o, 0);
    check("R4 clear crc", crc_o, 0);
    bit_vld_i = 1'b0; clr_i = 1'b0;

    // Random identifiers with bench-computed CRC byte
    for (int n = 0; n < 40; n++) begin
      id[31:0]  = $urandom;
      id[55:32] = 24'($urandom);
      id[63:56] = ref_crc56(id[55:0]);
      do_clear();
      rc = 8'h00;
      for (int i = 0; i < 64; i++) begin
        if ($urandom_range(0, 3) == 0) begin
          put(1'($urandom), 1'b0, 1'b0);
          check("R8 idle crc", crc_o, rc);
          check("R8 idle cnt", bit_cnt_o, i);
        end
        put(id[i], 1'b1, 1'b0);
        rc = ref_step(rc, id[i]);
        check("R1 crc", crc_o, rc);
        check("R2 cnt", bit_cnt_o, i + 1);
        if (i == 55) begin
          check("R5 crc byte", crc_o, id[63:56]);
          check("R5 gen flag", gen_done_o, 1);
        end
        if (i == 56) check("R5 gen low", gen_done_o, 0);
      end
      check("R6 good", crc_good_o, 1);
      for (int e = 0; e < 3; e++) put(1'($urandom), 1'b1, 1'b0);
      check("R7 crc held", crc_o, 0);
      check("R7 cnt held", bit_cnt_o, 64);
      check("R7 good held", crc_good_o, 1);
    end

    // Single-bit corruptions must not pass (R6)
    for (int n = 0; n < 12; n++) begin
      int pos;
      id[31:0]  = $urandom;
      id[55:32] = 24'($urandom);
      id[63:56] = ref_crc56(id[55:0]);
      pos = $urandom_range(0, 63);
      id[pos] = ~id[pos];
      do_clear();
      for (int i = 0; i < 64; i++) put(id[i], 1'b1, 1'b0);
      check("R6 corrupt cnt", bit_cnt_o, 64);
      check("R6 corrupt not good", crc_good_o, 0);
    end

    // Short stream: good stays low below 64 (R6)
    do_clear();
    for (int i = 0; i < 63; i++) put(1'b0, 1'b1, 1'b0);
    check("R6 short not good", crc_good_o, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule